// File: doc/BRIEF.md
# Coprocessor Register Binding Scoreboard

This block tracks ownership of the floating-point register file, the floating-point status register and the exception-address register. An FPU instruction that commits claims its write targets. It keeps them until its writeback releases them. While a target is claimed, a CPU write request aimed at it is refused and the CPU is told to stall. This keeps a later CPU write from landing before an older coprocessor write to the same location.

The status register is claimed as one whole unit. Whether the two special registers are claimed depends on the opcode class of the committing instruction. Each target has a small counter, so several in-flight instructions can hold the same target at once. The target stays claimed until every holder has released it.

Target index encoding, used by requests and releases: 0 to 31 are the data registers, 32 is the status register and 33 is the exception-address register. Opcode class encoding on `commitOp`: 0 arithmetic, 1 data move, 2 control move, 3 test, 4 logical AND/OR.

Top module: `fpuBindScoreboard`

## Requirements
- R1: After reset no target is claimed, so a request to any of the 34 targets is granted.
- R2: A commit with `commitHasDest` set claims data register `commitDest` from the next cycle on, and a request to it then gives stall=1 and grant=0.
- R3: A claim is held until a writeback release (`releaseMask` bit at the target index) brings the target's holder count back to zero. From the cycle after that release, a request to the target is granted.
- R4: Several commits to the same target stack. The target stays claimed until the same number of releases has arrived.
- R5: A release and a request to the same target in the same cycle are answered with stall, because the decision uses the state before the release.
- R6: The status register (index 32) is claimed by classes 0 and 3. Classes 1 and 2 never claim it. Class 4 claims it only when `commitModStatus` is 1.
- R7: The exception-address register (index 33) is claimed by class 0 only. Classes 1, 2 and 3 never claim it. Class 4 claims it only when `commitModExc` is 1.
- R8: `commitExcEnable` has no effect on any claim.
- R9: With `reqValid` low, grant and stall are both 0. With it high, exactly one of them is 1.
- R10: A claim affects only its own target. Requests to other targets are still granted.
- R11: Holder count per target saturates at neither end: the scoreboard never receives more than 2^CNT_W-1 holders or a release for an unclaimed target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, clears all claims |
| commitValid | input | 1 | An FPU instruction commits this cycle |
| commitHasDest | input | 1 | The committing instruction writes a data register |
| commitDest | input | 5 | Data register written by the committing instruction |
| commitOp | input | 3 | Opcode class of the committing instruction |
| commitModStatus | input | 1 | A logical op will modify the status register |
| commitModExc | input | 1 | A logical op will modify the exception-address register |
| commitExcEnable | input | 1 | Exception-address enable bit, ignored for claims |
| releaseMask | input | 34 | One bit per target: one holder finishes writeback |
| reqValid | input | 1 | CPU requests a write to a coprocessor target |
| reqTarget | input | 6 | Target index of the CPU write |
| grant | output | 1 | CPU write may proceed |
| stall | output | 1 | CPU write must wait |

## Verification
A holder counter that is wrong shows up at the ports in one of two ways. A counter that is too low grants a CPU write too early. A counter stuck above zero stalls a write forever. Either is visible on the first request to that target after the faulty commit or release. Wrong opcode decoding shows up the cycle after a commit, as a stall or grant on index 32 or 33. The bench therefore probes the targets one cycle after each commit and after each release, and it also probes targets that should be unaffected.

// File: rtl/fpuBindPkg.sv
package fpuBindPkg;
  localparam int NUM_DATA = 32;
  localparam int NUM_TGT  = NUM_DATA + 2;
  localparam int IDX_W    = $clog2(NUM_TGT);
  localparam int DEST_W   = $clog2(NUM_DATA);
  localparam int STAT_IDX = NUM_DATA;
  localparam int EXC_IDX  = NUM_DATA + 1;

  typedef enum logic [2:0] {
    OP_ARITH = 3'd0,
    OP_MOVD  = 3'd1,
    OP_MOVC  = 3'd2,
    OP_TEST  = 3'd3,
    OP_LOGIC = 3'd4
  } opClass_e;

  typedef struct packed {
    logic [NUM_TGT-1:0] inc;
    logic [NUM_TGT-1:0] dec;
  } bindStrobes_t;
endpackage

// File: rtl/fpuBindCtrl.sv
module fpuBindCtrl
  import fpuBindPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               commitValid,
  input  logic               commitHasDest,
  input  logic [DEST_W-1:0]  commitDest,
  input  logic [2:0]         commitOp,
  input  logic               commitModStatus,
  input  logic               commitModExc,
  input  logic [NUM_TGT-1:0] releaseMask,
  output bindStrobes_t       strobes
);
  opClass_e opCls;
  logic statusBind, excBind, dataBind;
  logic [NUM_DATA-1:0] dataOneHot;

  assign opCls = opClass_e'(commitOp);

  always_comb begin
    statusBind = 1'b0;
    excBind    = 1'b0;
    if (commitValid) begin
      unique case (opCls)
        OP_ARITH: begin statusBind = 1'b1; excBind = 1'b1; end
        OP_TEST:  statusBind = 1'b1;
        OP_LOGIC: begin statusBind = commitModStatus; excBind = commitModExc; end
        default:  ;
      endcase
    end
  end

  assign dataBind = commitValid && commitHasDest;

  always_comb begin
    dataOneHot = '0;
    if (dataBind) dataOneHot[commitDest] = 1'b1;
  end

  assign strobes.inc = {excBind, statusBind, dataOneHot};
  assign strobes.dec = releaseMask;

  // moves never touch the special registers
  assert_move_no_special_R6: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && (commitOp == 3'd1 || commitOp == 3'd2)) |->
      !strobes.inc[STAT_IDX] && !strobes.inc[EXC_IDX]);
  assert_test_no_exc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && commitOp == 3'd3) |-> !strobes.inc[EXC_IDX]);
  assert_one_data_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobes.inc[NUM_DATA-1:0]) <= 1);
endmodule

// File: rtl/fpuBindCounters.sv
module fpuBindCounters
  import fpuBindPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  bindStrobes_t       strobes,
  output logic [NUM_TGT-1:0] bound
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar t = 0; t < NUM_TGT; t++) begin : gTgt
    logic [CNT_W-1:0] holders;
    always_ff @(posedge clk) begin
      if (!rstN) holders <= '0;
      else if (strobes.inc[t] && !strobes.dec[t]) holders <= holders + 1'b1;
      else if (!strobes.inc[t] && strobes.dec[t]) holders <= holders - 1'b1;
    end
    assign bound[t] = (holders != '0);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes.inc[t] && !strobes.dec[t] && holders == CNT_MAX));
    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes.dec[t] && !strobes.inc[t] && holders == '0));
    assert_claim_sticks_R3: assert property (@(posedge clk) disable iff (!rstN)
      (bound[t] && !strobes.dec[t]) |=> bound[t]);
    assert_claim_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.inc[t] && !strobes.dec[t]) |=> bound[t]);
  end
endmodule

// File: rtl/fpuBindScoreboard.sv
module fpuBindScoreboard
  import fpuBindPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         commitValid,
  input  logic         commitHasDest,
  input  logic [4:0]   commitDest,
  input  logic [2:0]   commitOp,
  input  logic         commitModStatus,
  input  logic         commitModExc,
  input  logic         commitExcEnable,
  input  logic [33:0]  releaseMask,
  input  logic         reqValid,
  input  logic [5:0]   reqTarget,
  output logic         grant,
  output logic         stall
);
  bindStrobes_t        strobes;
  logic [NUM_TGT-1:0]  bound;
  logic                tgtBound;
  logic                unusedEnable;

  // the enable bit has no bearing on claiming the exception-address register
  assign unusedEnable = commitExcEnable;

  fpuBindCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .commitValid(commitValid), .commitHasDest(commitHasDest),
    .commitDest(commitDest), .commitOp(commitOp),
    .commitModStatus(commitModStatus), .commitModExc(commitModExc),
    .releaseMask(releaseMask), .strobes(strobes)
  );

  fpuBindCounters #(.CNT_W(CNT_W)) uCnt (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bound(bound)
  );

  assign tgtBound = (reqTarget < IDX_W'(NUM_TGT)) ? bound[reqTarget] : 1'b0;
  assign grant    = reqValid && !tgtBound;
  assign stall    = reqValid &&  tgtBound;

  assert_grant_stall_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $onehot({grant, stall}));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !grant && !stall);
endmodule

// File: tb/tb_fpuBindScoreboard.sv
module tb_fpuBindScoreboard;
  logic clk = 0, rstN = 0;
  logic commitValid = 0, commitHasDest = 0, commitModStatus = 0, commitModExc = 0, commitExcEnable = 0;
  logic [4:0] commitDest = 0;
  logic [2:0] commitOp = 0;
  logic [33:0] releaseMask = 0;
  logic reqValid = 0;
  logic [5:0] reqTarget = 0;
  logic grant, stall;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpuBindScoreboard dut (.*);

  task automatic check(input string req, input logic actual, input logic expected, input string what);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, actual, expected);
    end
  endtask

  // probe target at a negedge; expect stall when claimed
  task automatic probe(input string req, input int tgt, input bit expStall);
    reqValid = 1; reqTarget = 6'(tgt); #1;
    check(req, stall, expStall, $sformatf("stall tgt %0d", tgt));
    check(req, grant, !expStall, $sformatf("grant tgt %0d", tgt));
    reqValid = 0; #1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    commitValid = 0; commitHasDest = 0; commitModStatus = 0; commitModExc = 0;
    commitExcEnable = 0; releaseMask = 0;
  endtask

  task automatic commit(input int op, input bit hasDest, input int dest, input bit ms, input bit me, input bit en);
    commitValid = 1; commitOp = 3'(op); commitHasDest = hasDest; commitDest = 5'(dest);
    commitModStatus = ms; commitModExc = me; commitExcEnable = en;
    step();
  endtask

  task automatic release1(input int tgt);
    releaseMask = 34'd1 << tgt;
    step();
  endtask

  task automatic testReset();
    for (int t = 0; t < 34; t++) probe("R1", t, 0);
    reqValid = 0; #1;
    check("R9", grant, 0, "idle grant");
    check("R9", stall, 0, "idle stall");
  endtask

  task automatic testDataClaim();
    commit(1, 1, 7, 0, 0, 0);
    probe("R2", 7, 1);
    probe("R10", 6, 0);
    probe("R10", 8, 0);
    probe("R6", 32, 0);
    probe("R7", 33, 0);
    step();
    probe("R3", 7, 1);
    release1(7);
    probe("R3", 7, 0);
  endtask

  task automatic testStacking();
    commit(0, 1, 5, 0, 0, 0);
    commit(2, 1, 5, 0, 0, 0);
    release1(5);
    probe("R4", 5, 1);
    release1(33); release1(32);
    probe("R4", 5, 1);
    // R5: release and request together still stall
    releaseMask = 34'd1 << 5;
    probe("R5", 5, 1);
    step();
    probe("R5", 5, 0);
  endtask

  task automatic testSpecialDecode();
    commit(3, 0, 0, 0, 0, 0);
    probe("R6", 32, 1); probe("R7", 33, 0);
    release1(32);
    commit(4, 0, 0, 0, 0, 1);
    probe("R6", 32, 0); probe("R8", 33, 0);
    commit(4, 0, 0, 1, 0, 0);
    probe("R6", 32, 1); probe("R7", 33, 0);
    release1(32);
    commit(4, 0, 0, 0, 1, 0);
    probe("R6", 32, 0); probe("R7", 33, 1);
    release1(33);
    commit(0, 0, 0, 0, 0, 0);
    probe("R8", 33, 1); probe("R6", 32, 1);
    release1(32); release1(33);
    commit(0, 0, 0, 0, 0, 1);
    probe("R8", 33, 1);
    releaseMask = (34'd1 << 32) | (34'd1 << 33); step();
    probe("R8", 33, 0); probe("R3", 32, 0);
  endtask

  task automatic testEdgeRegs();
    commit(0, 1, 0, 0, 0, 0);
    commit(0, 1, 31, 0, 0, 0);
    probe("R2", 0, 1); probe("R2", 31, 1); probe("R10", 1, 0);
    releaseMask = (34'd1 << 0) | (34'd1 << 31) | (34'd3 << 32); step();
    releaseMask = (34'd3 << 32); step();
    for (int t = 0; t < 34; t++) probe("R3", t, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rstN = 1;
        testReset();
        testDataClaim();
        testStacking();
        testSpecialDecode();
        testEdgeRegs();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin nChecks++; nFails++; $display("FAIL watchdog expired"); end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule